// File: doc/BRIEF.md
# Three-Wire Nibble Register Port

This block is a slave serial port. A host uses it to reach a bank of sixteen 4-bit registers over three pins: an active-high chip enable, a shift clock and one bidirectional data line. The data line is modelled as separate input, output-value and output-enable signals. All three pins are brought into the fast system clock through two-flop synchronisers. Shift-clock rising edges are detected in that clock domain.

Every transaction is made of 4-bit fields, and each field is sent least significant bit first. The first field chooses write or read. The second field gives a start address. Each field after that goes to, or comes from, the current address, and the address then steps forward with wrap-around. The block drives the write port and the read address of an external register file.

It also gives two one-cycle strobes. One fires when a read of the control nibble at address 0xD completes, and the register bank uses it to clear its interrupt flag. The other fires when chip enable drops, and the bank uses it to clear its test bit, its reset bit and its read-carry flag.

Top module: `nibble_serial_slave`

## Requirements
- R1: After reset, and at all times while chip enable is low, `sdata_oe_o` is low and no write strobe is issued. Shift-clock and data toggling while chip enable is low has no effect.
- R2: Each field is 4 bits long and is shifted in least significant bit first, on rising edges of the shift clock. The first bit received is bit 0 of the field.
- R3: The first field after chip enable rises is the mode. The value 0x3 selects write and 0xC selects read. Any other value makes the block ignore every later bit until chip enable falls: there are no writes, and `sdata_oe_o` stays low.
- R4: The second field loads the start address. In write mode, each later complete field produces exactly one single-cycle `rf_we_o` pulse, with `rf_waddr_o` equal to the current address and `rf_wdata_o` equal to the field.
- R5: After each data field, in either mode, the current address increments by one and wraps from 0xF to 0x0.
- R6: In read mode, `sdata_oe_o` rises only after the address field is complete. Bit i of the nibble at the current address is driven after the shift-clock rising edge that ends the previous bit, so the host samples it while the clock is low, before the next rising edge.
- R7: If chip enable falls before a field is complete, the partial field is discarded. Fields that were already complete keep their effect.
- R8: Completing the read of a full nibble at address 0xD produces a one-cycle `ctl_rd_done_o` pulse. A partial read at 0xD and a write to 0xD produce no pulse.
- R9: Each falling edge of chip enable produces exactly one single-cycle `ce_fall_o` pulse, and the next transaction starts again from the mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the shift clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable pin, active high |
| sclk_i | input | 1 | Shift clock pin |
| sdata_i | input | 1 | Data line input value |
| sdata_o | output | 1 | Data line output value in read mode |
| sdata_oe_o | output | 1 | Data line output enable |
| rf_we_o | output | 1 | Register file write strobe |
| rf_waddr_o | output | 4 | Register file write address |
| rf_wdata_o | output | 4 | Register file write data |
| rf_raddr_o | output | 4 | Register file read address |
| rf_rdata_i | input | 4 | Register file read data |
| ctl_rd_done_o | output | 1 | Strobe: full read of address 0xD completed |
| ce_fall_o | output | 1 | Strobe: chip enable went low |

## Verification
The bench aims first at the address wrap from 0xF to 0x0 in both directions. A design that carried into a fifth bit, or stopped at 0xF, would write or read the wrong register. It sends unknown mode codes and follows them with fields that would look like a valid write if the design resynchronised in the middle of a frame. A design that did so would produce stray writes or drive the data line. It cuts a field short by dropping chip enable. A design that kept the partial bits would commit a corrupted nibble or raise a false control-read strobe. It also checks that the output enable stays low through the address field and that bits come out LSB first. A design that got either wrong would turn on the output too early or return a bit-reversed nibble.

// File: rtl/nss_pkg.sv
package nss_pkg;
  typedef enum logic [1:0] {
    PH_MODE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_SKIP = 2'd3
  } phase_e;
endpackage

// File: rtl/nss_sync.sv
module nss_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/nss_frame.sv
module nss_frame
  import nss_pkg::*;
#(
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned MODE_WR  = 'h3,
  parameter int unsigned MODE_RD  = 'hC,
  parameter int unsigned CTL_ADDR = 'hD,
  localparam int unsigned CNT_W   = $clog2(NIB_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             rise_i,
  input  logic             sd_i,
  output logic             wr_stb_o,
  output logic [NIB_W-1:0] wr_addr_o,
  output logic [NIB_W-1:0] wr_data_o,
  output logic             rd_done_o,
  output logic             rd_active_o,
  output logic             load_o,
  output logic [CNT_W-1:0] bit_idx_o,
  output logic [NIB_W-1:0] addr_o
);
  phase_e           ph;
  logic             rd_mode;
  logic [NIB_W-1:0] shreg, nib, addr;
  logic [CNT_W-1:0] bcnt;
  logic             nib_last;

  assign nib_last = (bcnt == CNT_W'(NIB_W-1));

  // field as it stands once the current bit is placed
  always_comb begin
    nib       = shreg;
    nib[bcnt] = sd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph        <= PH_MODE;
      rd_mode   <= 1'b0;
      shreg     <= '0;
      bcnt      <= '0;
      addr      <= '0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      rd_done_o <= 1'b0;
      load_o    <= 1'b0;
    end else begin
      wr_stb_o  <= 1'b0;
      rd_done_o <= 1'b0;
      load_o    <= 1'b0;
      if (!ce_i) begin
        ph      <= PH_MODE;
        rd_mode <= 1'b0;
        shreg   <= '0;
        bcnt    <= '0;
      end else if (rise_i && ph != PH_SKIP) begin
        shreg <= nib;
        bcnt  <= nib_last ? '0 : bcnt + 1'b1;
        if (nib_last) begin
          unique case (ph)
            PH_MODE: begin
              if (nib == NIB_W'(MODE_WR)) begin
                ph      <= PH_ADDR;
                rd_mode <= 1'b0;
              end else if (nib == NIB_W'(MODE_RD)) begin
                ph      <= PH_ADDR;
                rd_mode <= 1'b1;
              end else begin
                ph <= PH_SKIP;
              end
            end
            PH_ADDR: begin
              addr   <= nib;
              ph     <= PH_DATA;
              load_o <= rd_mode;
            end
            PH_DATA: begin
              addr <= addr + 1'b1;
              if (rd_mode) begin
                load_o    <= 1'b1;
                rd_done_o <= (addr == NIB_W'(CTL_ADDR));
              end else begin
                wr_stb_o  <= 1'b1;
                wr_addr_o <= addr;
                wr_data_o <= nib;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign rd_active_o = (ph == PH_DATA) && rd_mode;
  assign bit_idx_o   = bcnt;
  assign addr_o      = addr;
endmodule

// File: rtl/nss_rdpath.sv
module nss_rdpath #(
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned CNT_W = $clog2(NIB_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NIB_W-1:0] rdata_i,
  input  logic [CNT_W-1:0] bit_idx_i,
  input  logic             rd_active_i,
  input  logic             ce_pin_i,
  output logic             sdata_o,
  output logic             sdata_oe_o
);
  logic [NIB_W-1:0] rd_buf;

  // snapshot one whole nibble so a bank update cannot tear it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rd_buf <= '0;
    else if (load_i) rd_buf <= rdata_i;
  end

  assign sdata_o    = rd_buf[bit_idx_i];
  // raw pin gate releases the line without synchroniser delay
  assign sdata_oe_o = ce_pin_i & rd_active_i;
endmodule

// File: rtl/nibble_serial_slave.sv
module nibble_serial_slave #(
  parameter int unsigned NIB_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MODE_WR     = 'h3,
  parameter int unsigned MODE_RD     = 'hC,
  parameter int unsigned CTL_ADDR    = 'hD,
  localparam int unsigned CNT_W      = $clog2(NIB_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             sclk_i,
  input  logic             sdata_i,
  output logic             sdata_o,
  output logic             sdata_oe_o,
  output logic             rf_we_o,
  output logic [NIB_W-1:0] rf_waddr_o,
  output logic [NIB_W-1:0] rf_wdata_o,
  output logic [NIB_W-1:0] rf_raddr_o,
  input  logic [NIB_W-1:0] rf_rdata_i,
  output logic             ctl_rd_done_o,
  output logic             ce_fall_o
);
  logic [2:0]       pins_s;
  logic             ce_s, sclk_s, sd_s, ce_q, sclk_q, rise;
  logic             rd_active, load;
  logic [CNT_W-1:0] bit_idx;

  nss_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ce_i, sclk_i, sdata_i}),
    .q_o    (pins_s)
  );

  assign {ce_s, sclk_s, sd_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      ce_q   <= ce_s;
      sclk_q <= sclk_s;
    end
  end

  assign rise      = sclk_s & ~sclk_q;
  assign ce_fall_o = ce_q & ~ce_s;

  nss_frame #(
    .NIB_W    (NIB_W),
    .MODE_WR  (MODE_WR),
    .MODE_RD  (MODE_RD),
    .CTL_ADDR (CTL_ADDR)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ce_i        (ce_s),
    .rise_i      (rise),
    .sd_i        (sd_s),
    .wr_stb_o    (rf_we_o),
    .wr_addr_o   (rf_waddr_o),
    .wr_data_o   (rf_wdata_o),
    .rd_done_o   (ctl_rd_done_o),
    .rd_active_o (rd_active),
    .load_o      (load),
    .bit_idx_o   (bit_idx),
    .addr_o      (rf_raddr_o)
  );

  nss_rdpath #(.NIB_W(NIB_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .rdata_i     (rf_rdata_i),
    .bit_idx_i   (bit_idx),
    .rd_active_i (rd_active),
    .ce_pin_i    (ce_i),
    .sdata_o     (sdata_o),
    .sdata_oe_o  (sdata_oe_o)
  );
endmodule

// File: rtl/nss_checker.sv
module nss_checker #(
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned CTL_ADDR = 'hD
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sdata_oe_o,
  input logic             rf_we_o,
  input logic [NIB_W-1:0] rf_raddr_o,
  input logic             ctl_rd_done_o,
  input logic             ce_fall_o
);
  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> !rf_we_o); // R4

  AST_WE_NOT_WHILE_DRIVING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rf_we_o && sdata_oe_o)); // R3

  AST_CTL_DONE_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rd_done_o |-> rf_raddr_o == NIB_W'(CTL_ADDR + 1)); // R8

  AST_CTL_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rd_done_o |=> !ctl_rd_done_o); // R8

  AST_CE_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_fall_o |=> !ce_fall_o); // R9

  AST_CE_FALL_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_fall_o |=> !sdata_oe_o); // R1
endmodule

bind nibble_serial_slave nss_checker #(
  .NIB_W    (NIB_W),
  .CTL_ADDR (CTL_ADDR)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sdata_oe_o    (sdata_oe_o),
  .rf_we_o       (rf_we_o),
  .rf_raddr_o    (rf_raddr_o),
  .ctl_rd_done_o (ctl_rd_done_o),
  .ce_fall_o     (ce_fall_o)
);

// File: tb/sim_nibble_serial_slave.sv
module sim_nibble_serial_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce = 1'b0, sclk = 1'b0, sd = 1'b0;
  logic       sdata_o, sdata_oe, rf_we, ctl_done, ce_fall;
  logic [3:0] rf_waddr, rf_wdata, rf_raddr, rf_rdata;
  logic [3:0] regs [16];

  int n_chk = 0, n_fail = 0;
  int n_we = 0, n_done = 0, n_cef = 0, n_oe = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_serial_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclk_i(sclk), .sdata_i(sd),
    .sdata_o(sdata_o), .sdata_oe_o(sdata_oe), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .rf_raddr_o(rf_raddr),
    .rf_rdata_i(rf_rdata), .ctl_rd_done_o(ctl_done), .ce_fall_o(ce_fall)
  );

  // register bank model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= 4'h0;
    end else if (rf_we) begin
      regs[rf_waddr] <= rf_wdata;
    end
  end
  assign rf_rdata = regs[rf_raddr];

  always @(posedge clk) begin
    if (rst_n) begin
      if (rf_we)    n_we   <= n_we + 1;
      if (ctl_done) n_done <= n_done + 1;
      if (ce_fall)  n_cef  <= n_cef + 1;
      if (sdata_oe) n_oe   <= n_oe + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ce_up();
    sclk = 1'b0;
    ce = 1'b1;
    wclk(HALF);
  endtask

  task automatic ce_down();
    sclk = 1'b0;
    wclk(HALF);
    ce = 1'b0;
    wclk(2 * HALF);
  endtask

  task automatic send_bit(input logic b);
    sd = b;
    wclk(HALF);
    sclk = 1'b1;
    wclk(HALF);
    sclk = 1'b0;
  endtask

  task automatic send_nib(input logic [3:0] n);
    for (int i = 0; i < 4; i++) send_bit(n[i]);
  endtask

  task automatic read_nib(output logic [3:0] n);
    for (int i = 0; i < 4; i++) begin
      wclk(HALF);
      n[i] = sdata_o;
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic t_reset();
    wclk(2);
    chk(sdata_oe == 1'b0, "R1 oe after reset", sdata_oe, 0);
    chk(rf_we == 1'b0 && ctl_done == 1'b0 && ce_fall == 1'b0, "R1 strobes after reset",
        {rf_we, ctl_done, ce_fall}, 0);
  endtask

  task automatic t_idle_noise();
    int we0 = n_we, oe0 = n_oe;
    for (int i = 0; i < 12; i++) send_bit(i[0]);
    wclk(4);
    chk(n_we == we0, "R1 writes while ce low", n_we - we0, 0);
    chk(n_oe == oe0, "R1 oe while ce low", n_oe - oe0, 0);
  endtask

  task automatic t_write_wrap();
    int we0 = n_we, cef0 = n_cef;
    ce_up();
    send_nib(4'h3);
    send_nib(4'hE);
    send_nib(4'h5);
    send_nib(4'hA);
    send_nib(4'h7);
    send_nib(4'h3);
    ce_down();
    chk(n_we - we0 == 4, "R4 write strobe count", n_we - we0, 4);
    chk(regs[14] == 4'h5, "R4 first data at start addr", regs[14], 5);
    chk(regs[15] == 4'hA, "R2 lsb-first nibble", regs[15], 'hA);
    chk(regs[0] == 4'h7, "R5 write wrap F to 0", regs[0], 7);
    chk(regs[1] == 4'h3, "R5 write after wrap", regs[1], 3);
    chk(n_cef - cef0 == 1, "R9 one ce_fall pulse", n_cef - cef0, 1);
  endtask

  task automatic t_write_ctl();
    int done0 = n_done;
    ce_up();
    send_nib(4'h3);
    send_nib(4'hB);
    send_nib(4'h2);
    send_nib(4'h9);
    send_nib(4'h4);
    ce_down();
    chk(regs[13] == 4'h4, "R4 write at 0xD", regs[13], 4);
    chk(n_done == done0, "R8 no done on write", n_done - done0, 0);
  endtask

  task automatic t_read_seq();
    logic [3:0] got;
    logic [3:0] exp [4] = '{4'h2, 4'h9, 4'h4, 4'h5};
    int done0 = n_done;
    ce_up();
    send_nib(4'hC);
    send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b0);
    chk(sdata_oe == 1'b0, "R6 oe low before address done", sdata_oe, 0);
    send_bit(1'b1);
    wclk(HALF);
    chk(sdata_oe == 1'b1, "R6 oe high after address", sdata_oe, 1);
    for (int k = 0; k < 4; k++) begin
      read_nib(got);
      chk(got == exp[k], "R6 read nibble", got, exp[k]);
    end
    ce_down();
    chk(sdata_oe == 1'b0, "R1 oe released", sdata_oe, 0);
    chk(n_done - done0 == 1, "R8 done on full read of 0xD", n_done - done0, 1);
  endtask

  task automatic t_read_wrap();
    logic [3:0] got;
    ce_up();
    send_nib(4'hC);
    send_nib(4'hF);
    read_nib(got);
    chk(got == 4'hA, "R5 read at 0xF", got, 'hA);
    read_nib(got);
    chk(got == 4'h7, "R5 read wrap to 0x0", got, 7);
    ce_down();
  endtask

  task automatic t_bad_mode();
    int we0 = n_we, oe0 = n_oe;
    ce_up();
    send_nib(4'h5);
    send_nib(4'h3);
    send_nib(4'h8);
    send_nib(4'h1);
    send_nib(4'hC);
    send_nib(4'h2);
    ce_down();
    chk(n_we == we0, "R3 no write after bad mode", n_we - we0, 0);
    chk(n_oe == oe0, "R3 no drive after bad mode", n_oe - oe0, 0);
    chk(regs[8] == 4'h0, "R3 target reg untouched", regs[8], 0);
  endtask

  task automatic t_partial_write();
    int we0 = n_we;
    ce_up();
    send_nib(4'h3);
    send_nib(4'h4);
    send_nib(4'h6);
    send_bit(1'b1);
    send_bit(1'b1);
    ce_down();
    chk(n_we - we0 == 1, "R7 only complete nibble written", n_we - we0, 1);
    chk(regs[4] == 4'h6, "R7 complete nibble kept", regs[4], 6);
    chk(regs[5] == 4'h0, "R7 partial nibble dropped", regs[5], 0);
  endtask

  task automatic t_partial_read_ctl();
    logic [3:0] got;
    int done0 = n_done, cef0 = n_cef;
    ce_up();
    send_nib(4'hC);
    send_nib(4'hD);
    for (int i = 0; i < 2; i++) begin
      wclk(HALF);
      got[i] = sdata_o;
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
    ce_down();
    chk(n_done == done0, "R8 no done on partial read", n_done - done0, 0);
    ce_up();
    send_nib(4'hC);
    send_nib(4'hD);
    read_nib(got);
    ce_down();
    chk(got == 4'h4, "R9 frame restarts after ce low", got, 4);
    chk(n_done - done0 == 1, "R8 done after full read", n_done - done0, 1);
    chk(n_cef - cef0 == 2, "R9 ce_fall per deassertion", n_cef - cef0, 2);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    wclk(3);
    rst_n = 1'b1;
    t_reset();
    t_idle_noise();
    t_write_wrap();
    t_write_ctl();
    t_read_seq();
    t_read_wrap();
    t_bad_mode();
    t_partial_write();
    t_partial_read_ctl();
    finish_run();
  end
endmodule